// File: doc/BRIEF.md
# Serial Program Bootstrap Loader

This block fills a word-addressed program memory from a byte stream that arrives over a valid/ready handshake. The stream begins with a six-byte header. The first three bytes give the number of program words to load. The next three bytes give the memory address where loading starts. After the header, each program word arrives as a group of three bytes. Every three-byte group is little-endian: the least significant byte comes first.

The loader builds each 24-bit word from its bytes. It writes each word to the next memory address, starting at the header address and adding one after each write. When the last word has been written, it raises a sticky done flag and holds the start address on a jump-target output, so the processor core can branch there. After that it stops accepting bytes until reset.

Top module: `boot_loader`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release: `done` is 0, `in_ready` is 1 and `mem_we` is 0.
- R2: The first three accepted bytes form the word count, least significant byte first. Exactly that many memory writes occur before `done` rises.
- R3: The next three accepted bytes form the start address, least significant byte first. The first program word is written to that address.
- R4: Each program word is built from three accepted bytes, least significant first. It appears on `mem_data` as `{byte2, byte1, byte0}`.
- R5: Successive program words go to successive addresses, one higher each time. The address wraps from 24'hFFFFFF to 0.
- R6: `mem_we` is high for exactly one cycle per program word. That cycle is the one right after the clock edge that accepts the word's third byte, and `mem_addr`/`mem_data` are valid in it.
- R7: `done` rises on the same edge that produces the last write. From then on `jump_addr` equals the start address and stays stable.
- R8: A word count of 0 makes `done` rise on the edge that accepts the last address byte, with no memory write.
- R9: While `done` is high, `in_ready` is 0. Bytes offered then cause no write and do not change `done` or `jump_addr` until reset.
- R10: A byte is taken only on an edge where both `in_valid` and `in_ready` are high. Values on `in_byte` while `in_valid` is low have no effect.
- R11: A reset in the middle of a load discards any partial header and partial word. The next accepted byte is treated as byte 0 of a new word count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | `in_byte` holds a byte to transfer |
| in_ready | output | 1 | Loader can take a byte (low once done) |
| mem_addr | output | 24 | Program memory write address |
| mem_data | output | 24 | Program memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| done | output | 1 | Load complete, sticky until reset |
| jump_addr | output | 24 | Start address to branch to after loading |

## Verification
The assertions assume that `in_valid` and `in_byte` change only between clock edges. They also assume reset is released away from an edge, so no byte is half-accepted. The bench drives every input on the falling edge and releases reset there as well. It inserts random idle gaps with junk on `in_byte`, which checks that only handshaken bytes move the byte counter. Word counts stay small so that a run finishes quickly. Start addresses are random, and one directed case places the start near the top of the address space to force the wrap.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    LD_COUNT = 2'd0,
    LD_ADDR  = 2'd1,
    LD_DATA  = 2'd2,
    LD_DONE  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/boot_assembler.sv
module boot_assembler #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int WORD_W = BYTE_W * NBYTES,
  localparam int POS_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              word_ok,
  output logic [WORD_W-1:0] word
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NBYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;
  logic [BYTE_W-1:0] lane_q [NBYTES-1];

  always_comb begin
    pos_en = take;
    pos_d  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  for (genvar k = 0; k < NBYTES - 1; k++) begin : g_lane
    logic lane_en;
    assign lane_en = take && (pos_q == POS_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q[k] <= '0;
      else if (lane_en) lane_q[k] <= byte_in;
    end
  end

  always_comb begin
    word_ok = take && (pos_q == LAST_POS);
    word    = '0;
    for (int k = 0; k < NBYTES - 1; k++) word[k*BYTE_W +: BYTE_W] = lane_q[k];
    word[(NBYTES-1)*BYTE_W +: BYTE_W] = byte_in;
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pos_q)); // R10
endmodule

// File: rtl/boot_addr_ctr.sv
module boot_addr_ctr #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] addr
);
  logic [WORD_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = load || step;
    addr_d  = load ? load_val : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> addr_q == WORD_W'($past(addr_q) + 1)); // R5
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_ok,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] cur_addr,
  output logic              addr_load,
  output logic              addr_step,
  output ld_state_e         state,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              mem_we,
  output logic [WORD_W-1:0] jump_addr
);
  ld_state_e         state_q, state_d;
  logic [WORD_W-1:0] remain_q, remain_d;
  logic [WORD_W-1:0] start_q;
  logic              start_en;
  logic [WORD_W-1:0] waddr_q, wdata_q;
  logic              we_q, we_d;

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    start_en  = 1'b0;
    addr_load = 1'b0;
    addr_step = 1'b0;
    we_d      = 1'b0;
    unique case (state_q)
      LD_COUNT: if (word_ok) begin
        remain_d = word;
        state_d  = LD_ADDR;
      end
      LD_ADDR: if (word_ok) begin
        start_en  = 1'b1;
        addr_load = 1'b1;
        state_d   = (remain_q == '0) ? LD_DONE : LD_DATA;
      end
      LD_DATA: if (word_ok) begin
        we_d      = 1'b1;
        addr_step = 1'b1;
        remain_d  = remain_q - 1'b1;
        if (remain_q == WORD_W'(1)) state_d = LD_DONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= LD_COUNT;
      remain_q <= '0;
      we_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
      we_q     <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (start_en) start_q <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      waddr_q <= cur_addr;
      wdata_q <= word;
    end
  end

  assign state     = state_q;
  assign mem_addr  = waddr_q;
  assign mem_data  = wdata_q;
  assign mem_we    = we_q;
  assign jump_addr = start_q;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_DONE) |=> (state_q == LD_DONE)); // R9
  AST_JUMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_DONE) |=> $stable(start_q)); // R7
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_ADDR && word_ok && remain_q == '0)
      |=> (state_q == LD_DONE && !we_q)); // R8
  AST_WE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(state_q) == LD_DATA); // R6
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              mem_we,
  output logic              done,
  output logic [WORD_W-1:0] jump_addr
);
  ld_state_e         state;
  logic              take, word_ok, addr_load, addr_step;
  logic [WORD_W-1:0] word, cur_addr;

  assign in_ready = (state != LD_DONE);
  assign done     = (state == LD_DONE);
  assign take     = in_valid && in_ready;

  boot_assembler #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_byte),
    .word_ok(word_ok), .word(word)
  );

  boot_addr_ctr #(.WORD_W(WORD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(word),
    .step(addr_step), .addr(cur_addr)
  );

  boot_sequencer #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .word_ok(word_ok), .word(word),
    .cur_addr(cur_addr), .addr_load(addr_load), .addr_step(addr_step),
    .state(state), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_we(mem_we), .jump_addr(jump_addr)
  );

  AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> !mem_we); // R9
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !mem_we); // R10
endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic        in_ready, mem_we, done;
  logic [23:0] mem_addr, mem_data, jump_addr;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int gap_pct = 0;

  always #2 clk = ~clk;

  boot_loader uut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_we(mem_we), .done(done), .jump_addr(jump_addr)
  );

  always @(negedge clk) begin
    if (!rst_n) wr_cnt = 0;
    else if (mem_we) wr_cnt = wr_cnt + 1;
  end

  function automatic logic [23:0] exp_addr(logic [23:0] start, int i);
    return 24'(start + 24'(i));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (2) @(negedge clk);
    chk(done == 0 && in_ready == 1 && mem_we == 0, "R1 reset outputs",
        {29'd0, done, in_ready, mem_we}, 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && in_ready == 1 && mem_we == 0, "R1 after release",
        {29'd0, done, in_ready, mem_we}, 32'h2);
  endtask

  // R10: idle gaps carry junk bytes that must be ignored
  task automatic send_byte(logic [7:0] b);
    while (($urandom % 100) < gap_pct) begin
      in_valid = 1'b0; in_byte = 8'($urandom);
      @(negedge clk);
    end
    in_byte = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_byte = 8'($urandom);
  endtask

  task automatic send_word(logic [23:0] w);
    send_byte(w[7:0]); send_byte(w[15:8]); send_byte(w[23:16]);
  endtask

  task automatic run_load(int n, logic [23:0] start, int gaps);
    logic [23:0] w;
    gap_pct = gaps;
    do_reset();
    send_word(24'(n));
    send_word(start);
    chk(mem_we == 0, "R6 no write on header", {31'd0, mem_we}, 0);
    if (n == 0)
      chk(done == 1, "R8 zero count done after address", {31'd0, done}, 1);
    else
      chk(done == 0, "R2 not done before data", {31'd0, done}, 0);
    for (int i = 0; i < n; i++) begin
      w = 24'($urandom);
      send_word(w);
      chk(mem_we == 1, "R6 strobe after third byte", {31'd0, mem_we}, 1);
      chk(mem_addr == exp_addr(start, i),
          (i == 0) ? "R3 first write address" : "R5 address step",
          {8'd0, mem_addr}, {8'd0, exp_addr(start, i)});
      chk(mem_data == w, "R4 word byte order", {8'd0, mem_data}, {8'd0, w});
      chk(done == (i == n - 1), "R7 done on last write", {31'd0, done},
          {31'd0, (i == n - 1)});
      @(negedge clk);
      chk(mem_we == 0, "R6 single-cycle strobe", {31'd0, mem_we}, 0);
    end
    repeat (2) @(negedge clk);
    chk(wr_cnt == n, "R2 write count", wr_cnt, n);
    chk(jump_addr == start, "R7 jump target", {8'd0, jump_addr}, {8'd0, start});
    chk(in_ready == 0, "R9 ready low when done", {31'd0, in_ready}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [23:0] st;
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;

    run_load(1, 24'h000100, 0);
    run_load(0, 24'h0ABCDE, 20);                 // R8
    run_load(4, 24'hFFFFFE, 30);                 // R5 wrap
    for (int t = 0; t < 6; t++) begin
      run_load(1 + int'($urandom % 12), 24'($urandom), 40);   // R10 gaps
    end
    run_load(3, 24'h345678, 0);                   // byte order incl. 0x00 bytes

    // R9: bytes offered after done have no effect
    st = jump_addr;
    for (int k = 0; k < 9; k++) begin
      in_byte = 8'($urandom); in_valid = 1'b1;
      @(negedge clk);
      chk(mem_we == 0, "R9 no write after done", {31'd0, mem_we}, 0);
    end
    in_valid = 1'b0;
    chk(done == 1, "R9 done sticky", {31'd0, done}, 1);
    chk(jump_addr == st, "R9 jump stable", {8'd0, jump_addr}, {8'd0, st});

    // R11: reset mid-word, then a fresh load
    gap_pct = 0;
    do_reset();
    send_word(24'd7); send_word(24'h001000); send_word(24'h111111);
    send_byte(8'hAA);
    do_reset();
    chk(wr_cnt == 0, "R11 counter cleared", wr_cnt, 0);
    send_word(24'd2);
    send_word(24'h002000);
    send_word(24'hC0FFEE);
    chk(mem_we == 1 && mem_addr == 24'h002000, "R11 fresh header after reset",
        {8'd0, mem_addr}, 32'h002000);
    send_word(24'h123456);
    chk(done == 1 && mem_data == 24'h123456, "R11 load completes",
        {8'd0, mem_data}, 32'h123456);
    repeat (2) @(negedge clk);
    chk(wr_cnt == 2, "R11 write count", wr_cnt, 2);

    finish_run();
  end
endmodule